// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a synchronous DRAM from power-on to a usable state for a memory controller. When a start request arrives with a legal configuration, it waits a programmable number of idle clock cycles. It then issues one precharge-all-banks command, followed by a burst of dummy auto-refresh commands, and finally a mode register set command. It then reports completion. Every cycle that carries no command drives a NOP.

The mode word travels only on the address lines during the mode register set command. No data is written. The word is built from two inputs: a CAS latency (1 to 3) and a burst length (4 or 8). The number of dummy refreshes comes from an input and is never allowed to fall below eight. Only real auto-refresh commands are used for them, because ordinary reads and writes do not step the device's internal refresh address counter. The spacing between refreshes is the row-cycle time plus a short gap that applies only during this sequence. For a 200 µs idle wait at a 50 MHz clock, the idle count is set to 10000.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is held and afterwards until a start is accepted, the outputs show a NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1), address and bank are zero, and done and ready are low.
- R2: When start is high in a cycle where the sequencer is idle and the configuration is legal, a precharge-all command (cs_n=0, ras_n=0, cas_n=1, we_n=0) appears idle_cycles+2 cycles later. During that command address bit 10 is 1 and all other address bits and the bank lines are 0.
- R3: The number of auto-refresh commands (cs_n=0, ras_n=0, cas_n=0, we_n=1) between the precharge-all and the mode set equals ref_count, or 8 when ref_count is below 8.
- R4: The first refresh comes T_RP cycles after the precharge-all. Consecutive refreshes are T_RC+ref_gap cycles apart. The mode set comes T_RC cycles after the last refresh. Every cycle between commands is a NOP.
- R5: The mode set command (cs_n=0, ras_n=0, cas_n=0, we_n=0) carries the mode word on the address lines, with bank lines 0. Bits [2:0] are 010 for burst 4 and 011 for burst 8. Bit 3 is 0. Bits [6:4] hold the CAS latency as a binary value. All higher bits are 0.
- R6: done is high for exactly one cycle, T_MRD cycles after the mode set. ready rises in that same cycle and stays high until the next start is accepted, when it falls in the following cycle.
- R7: A start request while a sequence is running has no effect on that sequence.
- R8: A start request is ignored, with no command issued and ready unchanged, when cas_lat is 0 or burst_len is neither 4 nor 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the initialization sequence |
| idle_cycles | input | CNT_W | Idle wait length before the precharge-all |
| ref_count | input | RCNT_W | Requested number of dummy auto-refreshes (minimum 8 applied) |
| ref_gap | input | RCNT_W | Extra cycles added between consecutive refreshes |
| cas_lat | input | 2 | CAS latency, 1 to 3 |
| burst_len | input | 4 | Burst length, 4 or 8 |
| cs_n | output | 1 | SDRAM chip select, active low |
| ras_n | output | 1 | SDRAM row strobe, active low |
| cas_n | output | 1 | SDRAM column strobe, active low |
| we_n | output | 1 | SDRAM write enable, active low |
| addr | output | ADDR_W | SDRAM address bus |
| ba | output | BA_W | SDRAM bank lines |
| done | output | 1 | One-cycle completion pulse |
| ready | output | 1 | Initialization complete level |

## Verification
Every result has a fixed position counted from the first cycle after the clock edge that samples start. The precharge-all appears at cycle idle_cycles+2. Refresh n appears at cycle idle_cycles+2+T_RP+n·(T_RC+ref_gap). The mode set appears T_RC cycles after the last refresh, and done appears T_MRD cycles after the mode set. The bench drives inputs on falling edges and samples every output once per cycle on the falling edge. It records the cycle index of each command and compares those indices with the formulas above. A rejected or mid-sequence start is checked by watching the command pins over the following cycles.

// File: rtl/sdram_init_seq.sv
module sdram_init_seq #(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2,
  parameter int CNT_W  = 16,
  parameter int RCNT_W = 8,
  parameter int T_RP   = 3,
  parameter int T_RC   = 7,
  parameter int T_MRD  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  idle_cycles,
  input  logic [RCNT_W-1:0] ref_count,
  input  logic [RCNT_W-1:0] ref_gap,
  input  logic [1:0]        cas_lat,
  input  logic [3:0]        burst_len,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba,
  output logic              done,
  output logic              ready
);
  localparam logic [CNT_W-1:0]  RP_LD  = CNT_W'(T_RP - 2);
  localparam logic [CNT_W-1:0]  RC_LD  = CNT_W'(T_RC - 2);
  localparam logic [CNT_W-1:0]  MRD_LD = CNT_W'(T_MRD - 2);
  localparam logic [RCNT_W-1:0] MIN_REF = RCNT_W'(8);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_PALL, S_REF, S_MRS, S_DONE} st_t;

  st_t               state, nxt;
  logic [CNT_W-1:0]  cnt;
  logic [RCNT_W-1:0] rem, gap_q;
  logic [6:0]        mode_q;
  logic              ready_q;

  wire cfg_ok = (cas_lat != 2'd0) && (burst_len == 4'd4 || burst_len == 4'd8);
  wire [6:0] mode_w = {1'b0, cas_lat, 1'b0, 2'b01, burst_len == 4'd8};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      nxt     <= S_IDLE;
      cnt     <= '0;
      rem     <= '0;
      gap_q   <= '0;
      mode_q  <= '0;
      ready_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start && cfg_ok) begin
          state   <= S_WAIT;
          nxt     <= S_PALL;
          cnt     <= idle_cycles;
          ready_q <= 1'b0;
          mode_q  <= mode_w;
          gap_q   <= ref_gap;
          rem     <= (ref_count < MIN_REF) ? MIN_REF : ref_count;
        end
        S_WAIT: if (cnt == '0) state <= nxt;
                else cnt <= cnt - 1'b1;
        S_PALL: begin
          state <= S_WAIT;
          nxt   <= S_REF;
          cnt   <= RP_LD;
        end
        S_REF: begin
          rem   <= rem - 1'b1;
          state <= S_WAIT;
          if (rem == RCNT_W'(1)) begin
            nxt <= S_MRS;
            cnt <= RC_LD;
          end else begin
            nxt <= S_REF;
            cnt <= RC_LD + CNT_W'(gap_q);
          end
        end
        S_MRS: begin
          state <= S_WAIT;
          nxt   <= S_DONE;
          cnt   <= MRD_LD;
        end
        S_DONE: begin
          state   <= S_IDLE;
          ready_q <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    {cs_n, ras_n, cas_n, we_n} = 4'b0111;
    addr = '0;
    case (state)
      S_PALL: begin
        {cs_n, ras_n, cas_n, we_n} = 4'b0010;
        addr[10] = 1'b1;
      end
      S_REF: {cs_n, ras_n, cas_n, we_n} = 4'b0001;
      S_MRS: begin
        {cs_n, ras_n, cas_n, we_n} = 4'b0000;
        addr[6:0] = mode_q;
      end
      default: ;
    endcase
  end

  assign ba    = '0;
  assign done  = (state == S_DONE);
  assign ready = ready_q | done;
endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic [BA_W-1:0]   ba,
  input logic              done,
  input logic              ready
);
  wire [3:0] cmd = {cs_n, ras_n, cas_n, we_n};
  wire is_nop  = cmd == 4'b0111;
  wire is_pall = cmd == 4'b0010;
  wire is_ref  = cmd == 4'b0001;
  wire is_mrs  = cmd == 4'b0000;

  logic [7:0] ref_seen;
  logic       pall_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_seen  <= '0;
      pall_seen <= 1'b0;
    end else begin
      if (is_pall) begin
        pall_seen <= 1'b1;
        ref_seen  <= '0;
      end else if (is_ref && ref_seen != 8'hFF) ref_seen <= ref_seen + 1'b1;
      if (done) pall_seen <= 1'b0;
    end
  end

  // R1
  legal_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_nop || is_pall || is_ref || is_mrs);
  // R2
  pall_a10_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_pall |-> (addr == ADDR_W'(1 << 10)) && (ba == '0));
  // R3
  mrs_min_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_mrs |-> pall_seen && ref_seen >= 8'd8);
  // R3
  ref_after_pall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |-> pall_seen);
  // R4
  nop_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_nop |=> is_nop);
  // R5
  mode_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_mrs |-> addr[3] == 1'b0 && addr[2:1] == 2'b01 && addr[6:4] != 3'd0
               && addr[6:4] <= 3'd3 && addr[ADDR_W-1:7] == '0 && ba == '0);
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && ready);
  // R6
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ready);
endmodule

bind sdram_init_seq sdram_init_seq_chk #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .addr(addr), .ba(ba), .done(done), .ready(ready)
);

// File: tb/tb_sdram_init_seq.sv
`timescale 1ns/1ps
module tb_sdram_init_seq;
  localparam int ADDR_W = 13, BA_W = 2, CNT_W = 16, RCNT_W = 8;
  localparam int T_RP = 3, T_RC = 7, T_MRD = 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [CNT_W-1:0]  idle_cycles = '0;
  logic [RCNT_W-1:0] ref_count = '0, ref_gap = '0;
  logic [1:0] cas_lat = 2'd1;
  logic [3:0] burst_len = 4'd4;
  logic cs_n, ras_n, cas_n, we_n, done, ready;
  logic [ADDR_W-1:0] addr;
  logic [BA_W-1:0] ba;

  int checks = 0, fails = 0, cyc = 0;

  sdram_init_seq #(.ADDR_W(ADDR_W), .BA_W(BA_W), .CNT_W(CNT_W), .RCNT_W(RCNT_W),
    .T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .idle_cycles(idle_cycles),
    .ref_count(ref_count), .ref_gap(ref_gap), .cas_lat(cas_lat),
    .burst_len(burst_len), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .addr(addr), .ba(ba), .done(done), .ready(ready));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: act %0d cycles exp fewer", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: act %0d exp %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] cmd();
    return {cs_n, ras_n, cas_n, we_n};
  endfunction

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 outputs while in reset
    chk(cmd() == 4'b0111 && addr == '0 && ba == '0 && !done && !ready,
        "R1", "reset outputs", {cmd(), done, ready}, {4'b0111, 2'b00});
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cmd() == 4'b0111 && !done && !ready, "R1", "idle after reset",
        {cmd(), done, ready}, {4'b0111, 2'b00});
  endtask

  task automatic run_seq(input int idle, input int rc, input int gap,
                         input int cl, input int bl, input bit inject);
    int k = 1, pall_at = -1, mrs_at = -1, done_at = -1, nref = 0, bad = 0;
    int ref_bad = 0, nexp, first_ref;
    logic [ADDR_W-1:0] pall_addr = '0, mrs_addr = '0, mexp;
    logic [BA_W-1:0] cmd_ba = '0;
    int ref_at[64];
    idle_cycles = CNT_W'(idle); ref_count = RCNT_W'(rc); ref_gap = RCNT_W'(gap);
    cas_lat = 2'(cl); burst_len = 4'(bl);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    // R6 ready falls after an accepted start
    chk(!ready, "R6", "ready cleared on start", ready, 0);
    while (done_at < 0 && k < 4000) begin
      if (inject && k == 3) start = 1'b1;
      if (inject && k == 4) start = 1'b0;
      case (cmd())
        4'b0111: ;
        4'b0010: begin pall_at = k; pall_addr = addr; cmd_ba |= ba; end
        4'b0001: begin if (nref < 64) ref_at[nref] = k; nref++; end
        4'b0000: begin mrs_at = k; mrs_addr = addr; cmd_ba |= ba; end
        default: bad++;
      endcase
      if (done) done_at = k;
      k++;
      @(negedge clk);
    end
    nexp = (rc < 8) ? 8 : rc;
    first_ref = idle + 2 + T_RP;
    // R2 precharge-all position and address
    chk(pall_at == idle + 2, "R2", "pall cycle", pall_at, idle + 2);
    chk(pall_addr == ADDR_W'(1 << 10), "R2", "pall addr", pall_addr, 1 << 10);
    // R3 refresh count
    chk(nref == nexp, "R3", "refresh count", nref, nexp);
    // R4 spacing
    for (int i = 0; i < nref && i < 64; i++)
      if (ref_at[i] != first_ref + i * (T_RC + gap)) ref_bad++;
    chk(ref_bad == 0 && bad == 0, "R4", "refresh spacing/NOP", ref_bad + bad, 0);
    chk(mrs_at == first_ref + (nexp - 1) * (T_RC + gap) + T_RC, "R4", "mrs cycle",
        mrs_at, first_ref + (nexp - 1) * (T_RC + gap) + T_RC);
    // R5 mode word
    mexp = '0;
    mexp[6:4] = 3'(cl);
    mexp[2:0] = (bl == 8) ? 3'b011 : 3'b010;
    chk(mrs_addr == mexp && cmd_ba == '0, "R5", "mode word", mrs_addr, mexp);
    // R6 done timing and ready hold
    chk(done_at == mrs_at + T_MRD, "R6", "done cycle", done_at, mrs_at + T_MRD);
    chk(ready && !done, "R6", "ready held, done single", {ready, done}, 2'b10);
    if (inject) begin
      repeat (30) @(negedge clk);
      // R7 start during the run caused no second sequence
      chk(cmd() == 4'b0111 && ready, "R7", "no restart after busy start",
          {cmd(), ready}, {4'b0111, 1'b1});
    end
  endtask

  task automatic bad_cfg(input int cl, input int bl);
    int cmds = 0;
    bit rdy0 = ready;
    cas_lat = 2'(cl); burst_len = 4'(bl); idle_cycles = 2;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (60) begin
      if (cmd() != 4'b0111) cmds++;
      @(negedge clk);
    end
    // R8 rejected configuration
    chk(cmds == 0 && ready == rdy0, "R8", "illegal config ignored", cmds, 0);
  endtask

  initial begin
    test_reset();
    run_seq(5, 8, 0, 1, 4, 1'b0);
    run_seq(0, 9, 2, 2, 4, 1'b0);
    run_seq(3, 8, 1, 3, 4, 1'b0);
    run_seq(7, 10, 0, 1, 8, 1'b0);
    run_seq(1, 8, 3, 2, 8, 1'b0);
    run_seq(4, 3, 0, 3, 8, 1'b0);
    run_seq(2, 0, 1, 2, 4, 1'b0);
    run_seq(6, 8, 0, 1, 4, 1'b1);
    bad_cfg(0, 4);
    bad_cfg(2, 16);
    bad_cfg(1, 2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule